// File: doc/BRIEF.md
# Flow-Through DMA Engine

A single-channel DMA engine that moves a buffer between a serial peripheral's data register and system memory. It does not use an acknowledge strobe. Every item takes two ordinary bus cycles. The engine first reads the source and keeps the value in an internal holding register. It then writes that value to the destination. Because the peripheral sees a normal bus access to its data register, it drops its request during that access, just as it would if an acknowledge had been used.

Software loads a start address and a 16-bit byte count, then writes a control word. The control word picks the direction (receive: peripheral to memory; transmit: memory to peripheral) and the item size (byte or 16-bit word), and arms the engine. While armed, the engine starts an item whenever the request for the chosen direction and the bus grant are both high. After each item it advances the memory pointer and reduces the remaining count by the item size. When the count reaches zero it stops and signals done. It then ignores requests until software arms it again.

Top module: `fdma_engine`

## Requirements
- R1: Each item uses exactly two bus cycles: a read (`bus_rd_o`) followed by a write (`bus_wr_o`). The write drives on `bus_wdata_o` the value captured from `bus_rdata_i` when the read completed, and holds it through any wait states.
- R2: `bus_periph_o` is high during the cycle that accesses the peripheral. In receive mode (control bit 0 = 0) that is the read cycle, and the write goes to memory. In transmit mode (control bit 0 = 1) the read comes from memory and the write goes to the peripheral.
- R3: `bus_byte_o` is high during both cycles of a byte item and low during both cycles of a word item. Word mode (control bit 1 = 1) with one byte remaining moves a single byte item.
- R4: `bus_addr_o` shows the memory pointer. After each item the pointer advances by 1 (byte) or 2 (word), and the remaining count falls by the same amount.
- R5: When the write completes, the count is not exhausted, and the request and grant are high, the next read starts at the very next clock edge, with no idle cycle.
- R6: An item starts only while `bus_gnt_i` is high and the request of the selected direction is high (`rx_req_i` for receive, `tx_req_i` for transmit). The other direction's request has no effect.
- R7: When the count reaches zero, `done_o` rises, `busy_o` falls and no further cycles are issued, even if requests stay high. Arming with a count of zero gives done at once, with no bus cycle.
- R8: Register interface: `reg_sel_i` 0 = start address, 1 = byte count, 2 = control (bit 0 transmit, bit 1 word, bit 2 arm). Writes to any register are ignored while `busy_o` is high.
- R9: A bus cycle ends only on a clock edge where `bus_rdy_i` is high. Until then the strobe, address, select and size stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | REG_W | Register write data |
| rx_req_i | input | 1 | Peripheral receive request |
| tx_req_i | input | 1 | Peripheral transmit request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_rdy_i | input | 1 | Current bus cycle completes at this edge |
| bus_rdata_i | input | DATA_W | Read data |
| bus_addr_o | output | ADDR_W | Memory address |
| bus_wdata_o | output | DATA_W | Write data (held value) |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_byte_o | output | 1 | High for a byte item, low for a word item |
| bus_periph_o | output | 1 | High when the cycle addresses the peripheral |
| busy_o | output | 1 | Armed, count not exhausted |
| done_o | output | 1 | Count exhausted, waiting for re-arm |

## Verification
Two events can fall on the same edge: a write that completes the final item, and a request that is still high and would start the next item. The bench provokes this by holding the transmit request permanently high through a whole buffer with zero wait states. It judges the result in three ways. Every read must follow the previous write with no gap. The strobe count must match the buffer length exactly. Done must win over the pending request, so no strobe appears after the last write. A second case overlaps a peripheral read with the drop of the receive request, and checks that no extra item is started.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } fdma_state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam int CTL_TX   = 0;
  localparam int CTL_WORD = 1;
  localparam int CTL_ARM  = 2;
endpackage

// File: rtl/fdma_ptr.sv
module fdma_ptr #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_addr_i,
  input  logic              ld_cnt_i,
  input  logic [ADDR_W-1:0] addr_val_i,
  input  logic [CNT_W-1:0]  cnt_val_i,
  input  logic              step_i,
  input  logic              step_byte_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_inc;
  logic [CNT_W-1:0]  cnt_dec;

  assign addr_inc = step_byte_i ? ADDR_W'(1) : ADDR_W'(2);
  assign cnt_dec  = step_byte_i ? CNT_W'(1) : CNT_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ld_addr_i)   addr_q <= addr_val_i;
      else if (step_i) addr_q <= addr_q + addr_inc;
      if (ld_cnt_i)    cnt_q <= cnt_val_i;
      else if (step_i) cnt_q <= cnt_q - cnt_dec;
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;

  // R4: a step never takes more bytes than remain
  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (cnt_q >= cnt_dec));
endmodule

// File: rtl/fdma_hold.sv
module fdma_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '0;
    else if (cap_i) q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/fdma_ctrl.sv
module fdma_ctrl
  import fdma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             cfg_tx_i,
  input  logic             cfg_word_i,
  input  logic             rx_req_i,
  input  logic             tx_req_i,
  input  logic             gnt_i,
  input  logic             rdy_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             rd_o,
  output logic             wr_o,
  output logic             periph_o,
  output logic             byte_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             step_o,
  output logic             step_byte_o,
  output logic             cap_o
);
  fdma_state_e     state_q, state_d;
  logic            tx_q, word_q, byte_q, byte_d;
  logic            req_sel, go, idle_arm;
  logic [CNT_W-1:0] amt, cnt_after;

  assign req_sel   = tx_q ? tx_req_i : rx_req_i;
  assign go        = req_sel & gnt_i;
  assign amt       = byte_q ? CNT_W'(1) : CNT_W'(2);
  assign cnt_after = cnt_i - amt;
  assign idle_arm  = (state_q == ST_OFF) || (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    byte_d  = byte_q;
    unique case (state_q)
      ST_OFF, ST_DONE: begin
        if (arm_i) state_d = (cnt_i == '0) ? ST_DONE : ST_WAIT;
      end
      ST_WAIT: begin
        if (go) begin
          state_d = ST_READ;
          byte_d  = !word_q || (cnt_i == CNT_W'(1));
        end
      end
      ST_READ: begin
        if (rdy_i) state_d = ST_WRITE;
      end
      ST_WRITE: begin
        if (rdy_i) begin
          if (cnt_after == '0) begin
            state_d = ST_DONE;
          end else if (go) begin
            state_d = ST_READ;
            byte_d  = !word_q || (cnt_after == CNT_W'(1));
          end else begin
            state_d = ST_WAIT;
          end
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      tx_q    <= 1'b0;
      word_q  <= 1'b0;
      byte_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      byte_q  <= byte_d;
      if (arm_i && idle_arm) begin
        tx_q   <= cfg_tx_i;
        word_q <= cfg_word_i;
      end
    end
  end

  assign rd_o        = (state_q == ST_READ);
  assign wr_o        = (state_q == ST_WRITE);
  assign periph_o    = (rd_o & ~tx_q) | (wr_o & tx_q);
  assign byte_o      = byte_q & (rd_o | wr_o);
  assign busy_o      = (state_q == ST_WAIT) || rd_o || wr_o;
  assign done_o      = (state_q == ST_DONE);
  assign step_o      = wr_o & rdy_i;
  assign step_byte_o = byte_q;
  assign cap_o       = rd_o & rdy_i;

  // R1: a write only follows a completed read
  a_r1_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_o) |-> $past(rd_o && rdy_i));
  // R2: the two cycles of an item address opposite sides
  a_r2_sides_differ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && $past(rd_o)) |-> (periph_o != $past(periph_o)));
  // R3: item size is the same for read and write
  a_r3_size_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && $past(rd_o)) |-> (byte_o == $past(byte_o)));
  // R6: a read starts only with request and grant
  a_r6_start_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_o) |-> $past(req_sel && gnt_i));
  // R7: nothing issued once done
  a_r7_quiet_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rd_o && !wr_o && !busy_o));
  // R9: strobes held until ready
  a_r9_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && !rdy_i) |=> (rd_o && $stable(periph_o) && $stable(byte_o)));
  a_r9_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !rdy_i) |=> (wr_o && $stable(periph_o) && $stable(byte_o)));
endmodule

// File: rtl/fdma_engine.sv
module fdma_engine
  import fdma_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  localparam int REG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              rx_req_i,
  input  logic              tx_req_i,
  input  logic              bus_gnt_i,
  input  logic              bus_rdy_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic              bus_byte_o,
  output logic              bus_periph_o,
  output logic              busy_o,
  output logic              done_o
);
  logic             ld_addr, ld_cnt, arm;
  logic             step, step_byte, cap;
  logic [CNT_W-1:0] cnt;

  assign ld_addr = reg_we_i && (reg_sel_i == SEL_ADDR)  && !busy_o;
  assign ld_cnt  = reg_we_i && (reg_sel_i == SEL_COUNT) && !busy_o;
  assign arm     = reg_we_i && (reg_sel_i == SEL_CTRL)  && reg_wdata_i[CTL_ARM];

  fdma_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_addr_i   (ld_addr),
    .ld_cnt_i    (ld_cnt),
    .addr_val_i  (reg_wdata_i[ADDR_W-1:0]),
    .cnt_val_i   (reg_wdata_i[CNT_W-1:0]),
    .step_i      (step),
    .step_byte_i (step_byte),
    .addr_o      (bus_addr_o),
    .cnt_o       (cnt)
  );

  fdma_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .d_i    (bus_rdata_i),
    .q_o    (bus_wdata_o)
  );

  fdma_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm),
    .cfg_tx_i    (reg_wdata_i[CTL_TX]),
    .cfg_word_i  (reg_wdata_i[CTL_WORD]),
    .rx_req_i    (rx_req_i),
    .tx_req_i    (tx_req_i),
    .gnt_i       (bus_gnt_i),
    .rdy_i       (bus_rdy_i),
    .cnt_i       (cnt),
    .rd_o        (bus_rd_o),
    .wr_o        (bus_wr_o),
    .periph_o    (bus_periph_o),
    .byte_o      (bus_byte_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .step_o      (step),
    .step_byte_o (step_byte),
    .cap_o       (cap)
  );

  // R1: write drives the value captured by the preceding read
  a_r1_write_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o && $past(bus_rd_o && bus_rdy_i)) |-> (bus_wdata_o == $past(bus_rdata_i)));
  // R9: address stable during an unfinished cycle
  a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bus_rd_o || bus_wr_o) && !bus_rdy_i) |=> $stable(bus_addr_o));
endmodule

// File: tb/sim_fdma_engine.sv
module sim_fdma_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [23:0] reg_wdata;
  logic        rx_req, tx_req, gnt, rdy;
  logic [15:0] rdata;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_rd, bus_wr, bus_byte, bus_per, busy, done;

  always #10 clk = ~clk;

  fdma_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .rx_req_i(rx_req), .tx_req_i(tx_req),
    .bus_gnt_i(gnt), .bus_rdy_i(rdy), .bus_rdata_i(rdata),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rd_o(bus_rd),
    .bus_wr_o(bus_wr), .bus_byte_o(bus_byte), .bus_periph_o(bus_per),
    .busy_o(busy), .done_o(done)
  );

  int checks = 0, fails = 0;
  int cyc = 0, wait_n = 0, wcnt = 0;
  int rx_add = 0, rx_took = 0, tx_add = 0, tx_took = 0;
  bit hold_tx = 0;
  logic [15:0] rx_val;
  logic [7:0] wmem [256];
  bit         wval [256];
  bit   lg_rd [64], lg_per [64], lg_byte [64];
  int   nlog = 0, nstrobe = 0, first_s = -1, last_s = -1;
  logic [15:0] tx_log [16];
  bit          tx_blog [16];
  int   ntx = 0;
  bit   timeout = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] mem_rd(input int a);
    return wval[a] ? wmem[a] : pat(a);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic responder();
    forever begin
      @(negedge clk);
      cyc++;
      if (bus_rd || bus_wr) begin
        if (wcnt == wait_n) begin
          int a;
          a = int'(bus_addr[7:0]);
          rdy = 1'b1;
          wcnt = 0;
          nstrobe++;
          if (first_s < 0) first_s = cyc;
          last_s = cyc;
          if (nlog < 64) begin
            lg_rd[nlog] = bus_rd; lg_per[nlog] = bus_per; lg_byte[nlog] = bus_byte;
          end
          nlog++;
          if (bus_rd) begin
            if (bus_per) begin
              rdata = rx_val;
              rx_val = rx_val + 16'd1;
              rx_took++;
            end else if (bus_byte) rdata = {8'h00, mem_rd(a)};
            else rdata = {mem_rd((a + 1) % 256), mem_rd(a)};
          end else begin
            if (bus_per) begin
              if (ntx < 16) begin
                tx_log[ntx] = bus_wdata; tx_blog[ntx] = bus_byte;
              end
              ntx++;
              tx_took++;
            end else begin
              wmem[a] = bus_wdata[7:0]; wval[a] = 1'b1;
              if (!bus_byte) begin
                wmem[(a + 1) % 256] = bus_wdata[15:8]; wval[(a + 1) % 256] = 1'b1;
              end
            end
          end
        end else begin
          rdy = 1'b0;
          wcnt++;
        end
      end else begin
        rdy = 1'b0;
        wcnt = 0;
      end
      rx_req = (rx_add > rx_took);
      tx_req = hold_tx || (tx_add > tx_took);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [23:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic setup(input int addr, input int cnt, input bit tx, input bit word);
    reg_wr(2'd0, 24'(addr));
    reg_wr(2'd1, 24'(cnt));
    reg_wr(2'd2, {21'd0, 1'b1, word, tx});
  endtask

  task automatic clear_logs();
    for (int i = 0; i < 256; i++) wval[i] = 1'b0;
    nlog = 0; nstrobe = 0; first_s = -1; last_s = -1; ntx = 0;
  endtask

  task automatic wait_done(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  task automatic t_reset();
    chk("R7 reset done", done, 0);
    chk("R7 reset busy", busy, 0);
    chk("R1 reset strobes", {bus_rd, bus_wr}, 0);
  endtask

  task automatic t_rx_byte();
    clear_logs(); wait_n = 0; rx_val = 16'h00A1;
    setup(16'h10, 3, 0, 0);
    chk("R8 busy after arm", busy, 1);
    rx_add += 3;
    wait_done(100);
    chk("R7 rx done", done, 1);
    chk("R1 rx mem0", {wval[16], wmem[16]}, {1'b1, 8'hA1});
    chk("R1 rx mem1", wmem[17], 8'hA2);
    chk("R1 rx mem2", wmem[18], 8'hA3);
    chk("R4 rx no overrun", wval[19], 0);
    chk("R4 rx addr end", bus_addr, 24'h13);
    chk("R1 rx cycle count", nlog, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R1 rx order", lg_rd[i], (i % 2 == 0));
      chk("R2 rx select", lg_per[i], (i % 2 == 0));
      chk("R3 rx byte flag", lg_byte[i], 1);
    end
  endtask

  task automatic t_tx_word();
    clear_logs(); wait_n = 1;
    setup(16'h20, 4, 1, 1);
    tx_add += 2;
    wait_done(100);
    chk("R7 tx done", done, 1);
    chk("R2 tx count", ntx, 2);
    chk("R1 tx w0", tx_log[0], {pat(16'h21), pat(16'h20)});
    chk("R1 tx w1", tx_log[1], {pat(16'h23), pat(16'h22)});
    chk("R3 tx word flag", {tx_blog[0], tx_blog[1]}, 0);
    chk("R4 tx addr +2", bus_addr, 24'h24);
    chk("R2 tx read side", {lg_rd[0], lg_per[0], lg_per[1]}, 3'b101);
  endtask

  task automatic t_tx_odd();
    clear_logs(); wait_n = 0;
    setup(16'h30, 3, 1, 1);
    tx_add += 2;
    wait_done(100);
    chk("R3 odd count", ntx, 2);
    chk("R3 odd word", {tx_blog[0], tx_log[0]}, {1'b0, pat(16'h31), pat(16'h30)});
    chk("R3 odd tail byte", {tx_blog[1], tx_log[1]}, {1'b1, 8'h00, pat(16'h32)});
    chk("R4 odd addr", bus_addr, 24'h33);
  endtask

  task automatic t_wait_states();
    clear_logs(); wait_n = 3; rx_val = 16'hBEEF;
    setup(16'h40, 2, 0, 1);
    rx_add += 1;
    wait_done(100);
    chk("R9 ws done", done, 1);
    chk("R1 ws held data", {wmem[65], wmem[64]}, 16'hBEEF);
    chk("R9 ws cycles", nlog, 2);
    chk("R4 ws addr", bus_addr, 24'h42);
    wait_n = 0;
  endtask

  task automatic t_back_to_back();
    clear_logs(); wait_n = 0;
    setup(16'h60, 4, 1, 0);
    hold_tx = 1;
    wait_done(100);
    repeat (6) @(negedge clk);
    chk("R5 strobes", nstrobe, 8);
    chk("R5 no gap span", last_s - first_s + 1, 8);
    chk("R7 req high after done", {done, busy, bus_rd}, 3'b100);
    chk("R7 no extra tx", ntx, 4);
    hold_tx = 0;
    @(negedge clk);
  endtask

  task automatic t_done_ignores();
    clear_logs();
    rx_add += 3;
    repeat (10) @(negedge clk);
    chk("R7 ignored strobes", nstrobe, 0);
    chk("R7 req untouched", rx_req, 1);
    rx_took = rx_add;
    @(negedge clk);
  endtask

  task automatic t_zero_count();
    clear_logs();
    setup(16'h70, 0, 0, 0);
    chk("R7 zero count done", done, 1);
    rx_add += 1;
    repeat (5) @(negedge clk);
    chk("R7 zero no cycles", nstrobe, 0);
    rx_took = rx_add;
    @(negedge clk);
  endtask

  task automatic t_busy_writes();
    clear_logs(); rx_val = 16'h0011;
    setup(16'h50, 2, 0, 0);
    reg_wr(2'd0, 24'h90);
    reg_wr(2'd1, 24'd9);
    reg_wr(2'd2, 24'h7);
    rx_add += 2;
    wait_done(100);
    chk("R8 busy addr kept", {wmem[80], wmem[81]}, 16'h1112);
    chk("R8 busy no write at new addr", wval[144], 0);
    chk("R8 count kept", nlog, 4);
  endtask

  task automatic t_gating();
    clear_logs(); rx_val = 16'h00C3;
    setup(16'h80, 1, 0, 0);
    hold_tx = 1;
    repeat (6) @(negedge clk);
    chk("R6 wrong dir ignored", nstrobe, 0);
    hold_tx = 0; gnt = 0;
    rx_add += 1;
    repeat (6) @(negedge clk);
    chk("R6 no grant", nstrobe, 0);
    gnt = 1;
    wait_done(50);
    chk("R6 granted", {done, wmem[128]}, {1'b1, 8'hC3});
  endtask

  initial begin
    rst_n = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    rx_req = 0; tx_req = 0; gnt = 1; rdy = 0; rdata = 0; rx_val = 0;
    for (int i = 0; i < 256; i++) begin wval[i] = 0; wmem[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    fork
      responder();
      begin
        t_reset();
        t_rx_byte();
        t_tx_word();
        t_tx_odd();
        t_wait_states();
        t_back_to_back();
        t_done_ignores();
        t_zero_count();
        t_busy_writes();
        t_gating();
      end
      begin
        repeat (100000) @(posedge clk);
        timeout = 1;
      end
    join_any
    if (timeout) begin
      checks++; fails++;
      $display("FAIL watchdog act=1 exp=0");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule